// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date entirely in packed BCD. A free-running 32,768 Hz reference arrives as a single-cycle enable on the system clock. A prescaler counts these enables and produces one tick per second. Each tick advances a ripple of seven fields: seconds, minutes, 24-hour hours, weekday, day of month, month and a two-digit year. The month end follows the month's length. February gets its extra day in every year whose two-digit value is a multiple of four, which is correct through the end of the century.

Software or a host sequencer presets the whole calendar in one cycle through a parallel load strobe, which also clears the sub-second prescaler. A stop input freezes the prescaler and every field. A trim hook lets a calibration circuit drop single reference pulses, so the second can be stretched by whole reference periods.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 01, day 01, month 01, year 00, and sec_tick is low.
- R2: Each accepted reference pulse is a cycle with ref_en high, trim_skip low, stop low and load low. The TICK_DIV-th accepted pulse since the last load or wrap advances seconds on the clock edge that samples it. sec_tick is high for exactly the cycle after that edge.
- R3: Seconds and minutes count 00 to 59 in BCD. A tick at seconds 59 gives seconds 00 and increments minutes, and minutes wrap from 59 to 00 into hours.
- R4: Hours count 00 to 23. A wrap from 23:59:59 gives 00:00:00 and advances both weekday and day in the same edge.
- R5: Weekday counts 01 to 07 and wraps to 01, independent of the day of month.
- R6: Day of month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. The wrap increments the month.
- R7: In month 02 the day wraps after 29 when the BCD year is divisible by four (00 included), and after 28 otherwise.
- R8: Month counts 01 to 12. A wrap from 12 to 01 increments the year, and the year wraps from 99 to 00.
- R9: A cycle with load high writes all seven fields from the ld_* inputs at the next edge and clears the prescaler. Load takes priority over stop and over a coincident reference pulse, and sec_tick stays low in the cycle after a load.
- R10: While stop is high and load low, the prescaler count and all fields hold, and counting resumes from the held prescaler count when stop falls.
- R11: A reference pulse with trim_skip high is not counted and changes neither the prescaler nor any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_en | input | 1 | One-cycle enable per 32,768 Hz reference period |
| trim_skip | input | 1 | Drop the reference pulse of this cycle (calibration hook) |
| stop | input | 1 | Freeze prescaler and counters |
| load | input | 1 | Preset all fields and clear the prescaler |
| ld_seconds | input | 8 | Seconds preset, BCD 00-59 |
| ld_minutes | input | 8 | Minutes preset, BCD 00-59 |
| ld_hours | input | 8 | Hours preset, BCD 00-23 |
| ld_wday | input | 8 | Weekday preset, BCD 01-07 |
| ld_mday | input | 8 | Day-of-month preset, BCD 01-31 |
| ld_month | input | 8 | Month preset, BCD 01-12 |
| ld_year | input | 8 | Year preset, BCD 00-99 |
| seconds | output | 8 | Seconds, BCD |
| minutes | output | 8 | Minutes, BCD |
| hours | output | 8 | Hours, BCD, 24-hour |
| wday | output | 8 | Weekday, BCD 01-07 |
| mday | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Two-digit year, BCD |
| sec_tick | output | 1 | High for one cycle together with each new second value |

## Verification
A load shows up on the fields one edge after the strobe, so the bench reads them at the falling edge that follows. A second advances on the very edge that samples its last counted reference pulse, and sec_tick rises with it. The monitor therefore pops an expected calendar from the scoreboard at the falling edge after that pulse, and flags any tick that arrives with the queue empty. Negative checks for stop, trim and load-cleared prescaling hold back a known number of pulses and then confirm that no tick came. The one further pulse then produces the queued tick at its due edge.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Increment a packed BCD byte; the caller handles the upper limit.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // 10 = 2 (mod 4), so tens*2 + ones decides divisibility by four.
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic [4:0] m;
    m = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return (m[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic trim_skip,
  input  logic stop,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  assign accept = ref_en && !trim_skip && !stop && !clr;
  assign tick   = accept && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (tick)   cnt_d = '0;
    else if (accept) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_day
);
  import cal_pkg::*;

  always_comb begin
    unique case (month)
      8'h02:                      last_day = bcd_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_field.sv
module cal_field #(
  parameter logic [7:0] FIRST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic [7:0] last,
  output logic [7:0] val,
  output logic       carry
);
  import cal_pkg::*;

  logic [7:0] val_d;

  // Packed BCD orders like binary, so >= also catches an over-range preset.
  assign carry = step && (val >= last);

  always_comb begin
    val_d = val;
    if (ld)         val_d = ld_val;
    else if (carry) val_d = FIRST;
    else if (step)  val_d = bcd_inc(val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= FIRST;
    else        val <= val_d;
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       trim_skip,
  input  logic       stop,
  input  logic       load,
  input  logic [7:0] ld_seconds,
  input  logic [7:0] ld_minutes,
  input  logic [7:0] ld_hours,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_mday,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [7:0] wday,
  output logic [7:0] mday,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       sec_tick
);
  localparam int NF = 7;
  // Field order: 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year.
  localparam logic [7:0] FIRST_V [NF] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  logic       rst_meta, rst_sync_n;
  logic       tick, tick_g, sec_tick_d;
  logic [7:0] last_day;
  logic [7:0] lim   [NF];
  logic [7:0] ldv   [NF];
  logic [7:0] val   [NF];
  logic [NF-1:0] step, carry;
  logic       unused_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cal_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .ref_en(ref_en), .trim_skip(trim_skip),
    .stop(stop), .clr(load), .tick(tick)
  );

  assign tick_g = tick && !load;

  cal_month_len u_mlen (.month(val[5]), .year(val[6]), .last_day(last_day));

  assign lim = '{8'h59, 8'h59, 8'h23, 8'h07, last_day, 8'h12, 8'h99};
  assign ldv = '{ld_seconds, ld_minutes, ld_hours, ld_wday, ld_mday, ld_month, ld_year};

  always_comb begin
    step[0] = tick_g;
    step[1] = carry[0];
    step[2] = carry[1];
    step[3] = carry[2];
    step[4] = carry[2];
    step[5] = carry[4];
    step[6] = carry[5];
  end

  assign unused_carry = carry[3] ^ carry[6];

  generate
    for (genvar i = 0; i < NF; i++) begin : g_field
      cal_field #(.FIRST(FIRST_V[i])) u_f (
        .clk(clk), .rst_n(rst_sync_n), .step(step[i]), .ld(load),
        .ld_val(ldv[i]), .last(lim[i]), .val(val[i]), .carry(carry[i])
      );
    end
  endgenerate

  assign sec_tick_d = tick_g;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sec_tick <= 1'b0;
    else             sec_tick <= sec_tick_d;
  end

  assign seconds = val[0];
  assign minutes = val[1];
  assign hours   = val[2];
  assign wday    = val[3];
  assign mday    = val[4];
  assign month   = val[5];
  assign year    = val[6];
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       ref_en,
  input logic       trim_skip,
  input logic       stop,
  input logic       load,
  input logic [7:0] ld_seconds,
  input logic [7:0] ld_minutes,
  input logic [7:0] ld_hours,
  input logic [7:0] ld_wday,
  input logic [7:0] ld_mday,
  input logic [7:0] ld_month,
  input logic [7:0] ld_year,
  input logic [7:0] seconds,
  input logic [7:0] minutes,
  input logic [7:0] hours,
  input logic [7:0] wday,
  input logic [7:0] mday,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic       sec_tick
);
  import cal_pkg::*;

  logic [55:0] cal_now, cal_ld;
  assign cal_now = {seconds, minutes, hours, wday, mday, month, year};
  assign cal_ld  = {ld_seconds, ld_minutes, ld_hours, ld_wday, ld_mday, ld_month, ld_year};

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> (cal_now == $past(cal_ld)) && !sec_tick); // R9

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop && !load) |=> $stable(cal_now) && !sec_tick); // R10

  AST_NO_PULSE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((!ref_en || trim_skip) && !load) |=> $stable(cal_now) && !sec_tick); // R11

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_tick && $past(seconds) == 8'h59) |-> seconds == 8'h00); // R3

  AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_tick && $past(seconds) == 8'h59 && $past(minutes) != 8'h59)
      |-> minutes == bcd_inc($past(minutes))); // R3

  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_tick && $past({hours, minutes, seconds}) == 24'h235959)
      |-> (hours == 8'h00) && (mday != $past(mday))); // R4

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_tick && $past({wday, hours, minutes, seconds}) == 32'h07235959)
      |-> wday == 8'h01); // R5
endmodule

bind bcd_calendar cal_checker u_cal_chk (.*);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, ref_en, trim_skip, stop, load;
  logic [7:0] ld_seconds, ld_minutes, ld_hours, ld_wday, ld_mday, ld_month, ld_year;
  logic [7:0] seconds, minutes, hours, wday, mday, month, year;
  logic       sec_tick;

  bcd_calendar #(.TICK_DIV(DIV)) dut (.*);

  int n_chk = 0, n_fail = 0, ticks_seen = 0;
  bit done = 0;
  logic [55:0] exp_q[$];
  string       lbl_q[$];
  int m_s, m_mi, m_h, m_wd, m_dt, m_mo, m_yr;

  function automatic logic [7:0] i2b(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [55:0] cal_out();
    return {seconds, minutes, hours, wday, mday, month, year};
  endfunction

  function automatic logic [55:0] model_pack();
    return {i2b(m_s), i2b(m_mi), i2b(m_h), i2b(m_wd), i2b(m_dt), i2b(m_mo), i2b(m_yr)};
  endfunction

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    m_s++;
    if (m_s == 60) begin m_s = 0; m_mi++; end
    if (m_mi == 60) begin m_mi = 0; m_h++; end
    if (m_h == 24) begin
      m_h = 0;
      m_wd = (m_wd % 7) + 1;
      m_dt++;
      if (m_dt > days_in(m_mo, m_yr)) begin
        m_dt = 1; m_mo++;
        if (m_mo == 13) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
      end
    end
  endtask

  task automatic pulse(int n, bit skip);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ref_en = 1'b1; trim_skip = skip;
      @(negedge clk); ref_en = 1'b0; trim_skip = 1'b0;
    end
  endtask

  task automatic push_exp(string lbl);
    model_step();
    exp_q.push_back(model_pack());
    lbl_q.push_back(lbl);
  endtask

  task automatic run_secs(int n, string lbl);
    for (int k = 0; k < n; k++) begin
      push_exp(lbl);
      pulse(DIV, 1'b0);
    end
    @(negedge clk);
    check({lbl, " queue drained"}, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic do_load(int s, int mi, int h, int wd, int dt, int mo, int yr, bit with_ref);
    @(negedge clk);
    ld_seconds = i2b(s); ld_minutes = i2b(mi); ld_hours = i2b(h); ld_wday = i2b(wd);
    ld_mday = i2b(dt); ld_month = i2b(mo); ld_year = i2b(yr);
    load = 1'b1; ref_en = with_ref;
    @(negedge clk);
    load = 1'b0; ref_en = 1'b0;
    m_s = s; m_mi = mi; m_h = h; m_wd = wd; m_dt = dt; m_mo = mo; m_yr = yr;
    check("R9 load value", 64'(cal_out()), 64'(model_pack()));
    check("R9 no tick after load", 64'(sec_tick), 64'd0);
  endtask

  // Monitor: pops the scoreboard whenever the design announces a new second.
  always @(negedge clk) begin
    if (rst_n && sec_tick) begin
      ticks_seen++;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 unexpected tick actual=%h expected=none", cal_out());
      end else begin
        check(lbl_q.pop_front(), 64'(cal_out()), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int snap;
    rst_n = 1'b0; ref_en = 1'b0; trim_skip = 1'b0; stop = 1'b0; load = 1'b0;
    ld_seconds = '0; ld_minutes = '0; ld_hours = '0; ld_wday = '0;
    ld_mday = '0; ld_month = '0; ld_year = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset fields", 64'(cal_out()), 64'(56'h00_00_00_01_01_01_00));
    check("R1 reset tick", 64'(sec_tick), 64'd0);

    // R3: minute and hour carries
    do_load(58, 59, 9, 3, 15, 6, 21, 0);
    run_secs(3, "R3 sec/min carry");

    // R4 R5 R7: non-leap Feb 28 rollover, weekday 07 -> 01
    do_load(58, 59, 23, 7, 28, 2, 23, 0);
    run_secs(2, "R4 R5 R7 Feb28 non-leap");

    // R7: leap year Feb 28 -> 29 -> Mar 01
    do_load(59, 59, 23, 2, 28, 2, 24, 0);
    run_secs(1, "R7 Feb28 leap");
    do_load(59, 59, 23, 3, 29, 2, 24, 0);
    run_secs(1, "R7 Feb29 to Mar01");

    // R7: year 00 counts as leap
    do_load(59, 59, 23, 4, 28, 2, 0, 0);
    run_secs(1, "R7 year 00 leap");

    // R6: 30-day and 31-day months
    do_load(59, 59, 23, 5, 30, 4, 10, 0);
    run_secs(1, "R6 Apr30");
    do_load(59, 59, 23, 6, 30, 5, 10, 0);
    run_secs(1, "R6 May30 stays May");
    do_load(59, 59, 23, 1, 30, 11, 10, 0);
    run_secs(1, "R6 Nov30");

    // R8: end of century
    do_load(59, 59, 23, 7, 31, 12, 99, 0);
    run_secs(1, "R8 Dec31 99");

    // R2 R10: prescaler holds under stop and resumes
    do_load(10, 20, 5, 2, 3, 8, 40, 0);
    snap = ticks_seen;
    pulse(2, 1'b0);
    stop = 1'b1;
    pulse(6, 1'b0);
    check("R10 frozen fields", 64'(cal_out()), 64'(model_pack()));
    check("R10 no tick while stopped", 64'(ticks_seen), 64'(snap));
    stop = 1'b0;
    pulse(1, 1'b0);
    check("R2 no tick before count", 64'(ticks_seen), 64'(snap));
    push_exp("R2 R10 resume tick");
    pulse(1, 1'b0);
    @(negedge clk);
    check("R2 tick after count", 64'(ticks_seen), 64'(snap + 1));

    // R11: skipped pulses are not counted
    snap = ticks_seen;
    pulse(3, 1'b0);
    pulse(5, 1'b1);
    check("R11 skipped pulses", 64'(ticks_seen), 64'(snap));
    check("R11 fields unchanged", 64'(cal_out()), 64'(model_pack()));
    push_exp("R11 tick after skip");
    pulse(1, 1'b0);
    @(negedge clk);
    check("R11 tick count", 64'(ticks_seen), 64'(snap + 1));

    // R9: load clears prescaler and wins over stop and reference pulse
    pulse(3, 1'b0);
    stop = 1'b1;
    do_load(0, 0, 12, 4, 9, 9, 9, 1);
    stop = 1'b0;
    snap = ticks_seen;
    pulse(3, 1'b0);
    check("R9 prescaler cleared", 64'(ticks_seen), 64'(snap));
    push_exp("R9 first tick after load");
    pulse(1, 1'b0);
    @(negedge clk);
    check("R9 tick count", 64'(ticks_seen), 64'(snap + 1));

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule